// File: doc/BRIEF.md
# SMBus Transaction Sequencer

This block runs one complete SMBus transaction on top of a byte-level I2C master engine. The host presents a 7-bit target address, a direction flag, a command byte, a transaction type and a block length, then pulses `go`. The sequencer asks the engine for START, repeated START and STOP. It hands the engine the address byte, the command byte and each data byte, and it picks ACK or NACK for every byte it receives. When the transaction ends it pulses `done` together with a result code.

Write data arrives from the host over a valid/ready byte port. Received bytes go back to the host over a valid-only port that the host must always accept. The engine reports each finished step with an event. An event is a byte-done, a no-acknowledge or a bus error, and each event comes with a level that says whether the engine still holds the bus. A watchdog counter ends any step that receives no event.

A bus error, a loss of the bus or a timeout leaves the engine in an unknown condition. In that case the sequencer runs a fixed recovery sequence on a separate step port before it reports `done`.

States:
- `S_IDLE` waits for `go`.
- `S_ADDR` waits for START to finish.
- `S_CMD` waits for the address byte with the write bit.
- `S_RSTART` waits for the command byte before a read.
- `S_QUICK` waits for START on the types without a command.
- `S_RFIRST` waits for the read address byte.
- `S_READ` takes each received byte.
- `S_WRITE` waits for each written byte.
- `S_FETCH` waits for the host's next write byte.
- `S_RECOV` runs the recovery steps.
- `S_DONE` pulses completion.

Transitions:
- `S_IDLE` goes to `S_ADDR`, to `S_QUICK`, or (on a rejected request) to `S_DONE`.
- `S_ADDR` goes to `S_CMD`.
- `S_CMD` goes to `S_RSTART` on a read and to `S_WRITE` on a write.
- `S_RSTART` goes to `S_RFIRST`.
- `S_QUICK` goes to `S_RFIRST` on a read and to `S_WRITE` on a write.
- `S_RFIRST` goes to `S_READ`.
- `S_READ` loops on itself, then goes to `S_DONE`.
- `S_WRITE` goes to `S_FETCH`, or to `S_DONE` when no bytes remain.
- `S_FETCH` goes back to `S_WRITE`.
- Any wait state goes to `S_DONE` on a no-acknowledge.
- Any wait state goes to `S_RECOV` on a bus error, a lost bus or a timeout.
- `S_RECOV` goes to `S_DONE`.
- `S_DONE` goes to `S_IDLE`.

Top module: `smbus_seq`

## Requirements
- R1: For types 2 (byte-data), 3 (word) and 4 (block), the sequencer requests START and then writes the address byte {addr[6:0],0}. After that event it writes the command byte.
- R2: On a read of types 2 to 4, the event that follows the command byte makes the sequencer request a repeated START and, in the same cycle, write {addr[6:0],1}. It then issues reads.
- R3: For types 0 (quick) and 1 (byte), the event that follows START makes the sequencer write {addr[6:0],rd} directly, with no command byte.
- R4: The byte count is 0 for type 0, 1 for types 1 and 2, 2 for type 3, and `blk_len` for type 4.
- R5: A read whose byte count is zero issues no engine request. It gives `done` in the cycle after `go`, with result 3 (invalid).
- R6: A read issues one read request per byte. `eng_nack` is 1 only on the request for the final byte. Every received byte appears on `rx_data` with `rx_valid`. After the final byte the sequencer requests STOP and reports result 0.
- R7: A write takes each data byte through the `tx_valid`/`tx_ready` handshake and writes it to the engine. When the count has reached zero, the next byte-done event makes the sequencer request STOP and report result 0. A block write of length 0 sends only address and command.
- R8: A no-acknowledge event in any wait state requests STOP in the same cycle. It reports result 1 and runs no recovery.
- R9: A bus-error event, or any event that arrives with `ev_master` low, ends the transaction with result 2 and triggers recovery.
- R10: If a wait state sees no event for `TMO_CYC` cycles, the transaction ends with result 2 and recovery. The first recovery step appears `TMO_CYC`+1 cycles after the engine request that went unanswered.
- R11: Recovery drives `rcv_op` codes 0 to 6 on consecutive cycles, with `rcv_valid` high:
  - 0 turns the engine off.
  - 1 reloads the clock divider.
  - 2 clears the control bits.
  - 3 turns the slave address off.
  - 4 turns the engine on.
  - 5 sends STOP.
  - 6 clears the error, no-ack, stall and busy flags.

  `done` follows in the next cycle.
- R12: An engine event that arrives while the block is idle causes no engine request and leaves `busy` low. It sets `spurious`, which stays set until reset.
- R13: `done` is a one-cycle pulse, and `busy` is low in the cycle after it. A `go` that arrives while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start a transaction (sampled when idle) |
| tgt_addr | input | 7 | Target address |
| rd | input | 1 | 1 = read, 0 = write |
| cmd | input | 8 | Command byte |
| xtype | input | 3 | 0 quick, 1 byte, 2 byte-data, 3 word, 4 block |
| blk_len | input | LEN_W | Byte count for block type |
| tx_data | input | 8 | Write byte from host |
| tx_valid | input | 1 | Write byte available |
| tx_ready | output | 1 | Write byte taken |
| rx_data | output | 8 | Received byte to host |
| rx_valid | output | 1 | Received byte strobe |
| eng_start | output | 1 | START / repeated START request |
| eng_stop | output | 1 | STOP request |
| eng_wr | output | 1 | Write byte request |
| eng_wbyte | output | 8 | Byte to write |
| eng_rd | output | 1 | Read byte request |
| eng_nack | output | 1 | NACK the byte being read |
| ev_done | input | 1 | Engine step finished |
| ev_rbyte | input | 8 | Byte received by engine |
| ev_nack | input | 1 | Target did not acknowledge |
| ev_berr | input | 1 | Bus error |
| ev_master | input | 1 | Engine still owns the bus |
| rcv_valid | output | 1 | Recovery step strobe |
| rcv_op | output | 3 | Recovery step code |
| done | output | 1 | Transaction finished |
| result | output | 2 | 0 ok, 1 no device, 2 I/O error, 3 invalid |
| busy | output | 1 | Transaction in progress |
| spurious | output | 1 | Sticky idle-event flag |

## Verification
The bench builds the block with `TMO_CYC` = 40 instead of the large default. This makes the timeout path, and its exact latency, reachable in a few dozen cycles. The behavioural engine model answers every request after 3 cycles. It can turn the k-th event into a no-acknowledge, a bus error, a lost bus or silence. This reaches the fault exits from every wait state used, including mid-block data.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;

    typedef enum logic [2:0] {
        XT_QUICK = 3'd0,
        XT_BYTE  = 3'd1,
        XT_BDATA = 3'd2,
        XT_WORD  = 3'd3,
        XT_BLOCK = 3'd4
    } xtype_e;

    typedef enum logic [1:0] {
        RES_OK    = 2'd0,
        RES_NODEV = 2'd1,
        RES_IOERR = 2'd2,
        RES_INVAL = 2'd3
    } res_e;

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_CMD, S_RSTART, S_QUICK, S_RFIRST,
        S_READ, S_WRITE, S_FETCH, S_RECOV, S_DONE
    } st_e;

    // recovery step codes, issued in this order
    typedef enum logic [2:0] {
        RCV_ENG_OFF   = 3'd0,
        RCV_DIVIDER   = 3'd1,
        RCV_CTL_CLR   = 3'd2,
        RCV_SLV_OFF   = 3'd3,
        RCV_ENG_ON    = 3'd4,
        RCV_STOP      = 3'd5,
        RCV_FLAGS_CLR = 3'd6
    } rcv_e;

    localparam int RCV_STEPS = 7;

endpackage

// File: rtl/smbus_len_dec.sv
module smbus_len_dec #(
    parameter int LEN_W = 8
) (
    input  logic [2:0]       xtype,
    input  logic [LEN_W-1:0] blk_len,
    output logic [LEN_W-1:0] len,
    output logic             has_cmd
);
    import smbus_seq_pkg::*;

    always_comb begin
        len     = '0;
        has_cmd = 1'b0;
        unique case (xtype)
            XT_QUICK: len = '0;
            XT_BYTE:  len = LEN_W'(1);
            XT_BDATA: begin len = LEN_W'(1); has_cmd = 1'b1; end
            XT_WORD:  begin len = LEN_W'(2); has_cmd = 1'b1; end
            XT_BLOCK: begin len = blk_len;   has_cmd = 1'b1; end
            default:  len = '0;
        endcase
    end
endmodule

// File: rtl/smbus_wdog.sv
module smbus_wdog #(
    parameter int TMO_CYC = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic kick,
    output logic expire
);
    localparam int CW = $clog2(TMO_CYC + 1);

    logic [CW-1:0] cnt_q;

    assign expire = arm && !kick && (cnt_q == CW'(TMO_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!arm || kick || expire)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/smbus_seq.sv
module smbus_seq #(
    parameter int LEN_W   = 8,
    parameter int TMO_CYC = 1_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [6:0]       tgt_addr,
    input  logic             rd,
    input  logic [7:0]       cmd,
    input  logic [2:0]       xtype,
    input  logic [LEN_W-1:0] blk_len,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             eng_start,
    output logic             eng_stop,
    output logic             eng_wr,
    output logic [7:0]       eng_wbyte,
    output logic             eng_rd,
    output logic             eng_nack,
    input  logic             ev_done,
    input  logic [7:0]       ev_rbyte,
    input  logic             ev_nack,
    input  logic             ev_berr,
    input  logic             ev_master,
    output logic             rcv_valid,
    output logic [2:0]       rcv_op,
    output logic             done,
    output logic [1:0]       result,
    output logic             busy,
    output logic             spurious
);
    import smbus_seq_pkg::*;

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
    localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

    st_e              st_q, st_d;
    logic [LEN_W-1:0] len_q, len_d;
    res_e             res_q, res_d;
    logic [2:0]       step_q, step_d;
    logic [6:0]       addr_q;
    logic [7:0]       cmd_q;
    logic             rd_q, spur_q;

    logic [LEN_W-1:0] dec_len;
    logic             dec_cmd;
    logic             wait_st, ev_any, tmo_exp;
    logic             err_ev, nack_ev, ok_ev, go_ok, go_bad;

    smbus_len_dec #(.LEN_W(LEN_W)) len_dec_i (
        .xtype   (xtype),
        .blk_len (blk_len),
        .len     (dec_len),
        .has_cmd (dec_cmd)
    );

    smbus_wdog #(.TMO_CYC(TMO_CYC)) wdog_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (wait_st),
        .kick   (ev_any),
        .expire (tmo_exp)
    );

    assign ev_any  = ev_done | ev_nack | ev_berr;
    assign wait_st = st_q inside {S_ADDR, S_CMD, S_RSTART, S_QUICK,
                                  S_RFIRST, S_READ, S_WRITE};
    assign err_ev  = wait_st && (tmo_exp || (ev_any && (ev_berr || !ev_master)));
    assign nack_ev = wait_st && ev_any && !ev_berr && ev_master && ev_nack;
    assign ok_ev   = wait_st && ev_any && !ev_berr && ev_master && !ev_nack;
    assign go_ok   = (st_q == S_IDLE) && go && !(rd && dec_len == '0);
    assign go_bad  = (st_q == S_IDLE) && go &&  (rd && dec_len == '0);

    // state and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            len_q  <= '0;
            res_q  <= RES_OK;
            step_q <= '0;
            addr_q <= '0;
            cmd_q  <= '0;
            rd_q   <= 1'b0;
            spur_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            len_q  <= len_d;
            res_q  <= res_d;
            step_q <= step_d;
            spur_q <= spur_q | ((st_q == S_IDLE) && ev_any);
            if (st_q == S_IDLE && go) begin
                addr_q <= tgt_addr;
                cmd_q  <= cmd;
                rd_q   <= rd;
            end
        end
    end

    // next state
    always_comb begin
        st_d   = st_q;
        len_d  = len_q;
        res_d  = res_q;
        step_d = step_q;
        if (err_ev) begin
            st_d   = S_RECOV;
            res_d  = RES_IOERR;
            step_d = '0;
        end else if (nack_ev) begin
            st_d  = S_DONE;
            res_d = RES_NODEV;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    len_d = dec_len;
                    if (go_bad) begin
                        st_d  = S_DONE;
                        res_d = RES_INVAL;
                    end else if (go_ok) begin
                        st_d = dec_cmd ? S_ADDR : S_QUICK;
                    end
                end
                S_ADDR:   if (ok_ev) st_d = S_CMD;
                S_CMD:    if (ok_ev) st_d = rd_q ? S_RSTART : S_WRITE;
                S_RSTART: if (ok_ev) st_d = S_RFIRST;
                S_QUICK:  if (ok_ev) st_d = rd_q ? S_RFIRST : S_WRITE;
                S_RFIRST: if (ok_ev) st_d = S_READ;
                S_READ: if (ok_ev) begin
                    if (len_q == ONE) begin
                        st_d  = S_DONE;
                        res_d = RES_OK;
                    end else begin
                        len_d = len_q - ONE;
                    end
                end
                S_WRITE: if (ok_ev) begin
                    if (len_q == '0) begin
                        st_d  = S_DONE;
                        res_d = RES_OK;
                    end else begin
                        st_d = S_FETCH;
                    end
                end
                S_FETCH: if (tx_valid) begin
                    len_d = len_q - ONE;
                    st_d  = S_WRITE;
                end
                S_RECOV: begin
                    step_d = step_q + 3'd1;
                    if (step_q == 3'(RCV_STEPS - 1)) st_d = S_DONE;
                end
                S_DONE:  st_d = S_IDLE;
                default: st_d = S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        eng_start = go_ok;
        eng_stop  = nack_ev;
        eng_wr    = 1'b0;
        eng_wbyte = '0;
        eng_rd    = 1'b0;
        eng_nack  = 1'b0;
        tx_ready  = 1'b0;
        rx_valid  = 1'b0;
        if (ok_ev) begin
            unique case (st_q)
                S_ADDR:   begin eng_wr = 1'b1; eng_wbyte = {addr_q, 1'b0}; end
                S_CMD:    begin eng_wr = 1'b1; eng_wbyte = cmd_q; end
                S_RSTART: begin
                    eng_start = 1'b1;
                    eng_wr    = 1'b1;
                    eng_wbyte = {addr_q, 1'b1};
                end
                S_QUICK:  begin eng_wr = 1'b1; eng_wbyte = {addr_q, rd_q}; end
                S_RFIRST: begin eng_rd = 1'b1; eng_nack = (len_q == ONE); end
                S_READ: begin
                    rx_valid = 1'b1;
                    if (len_q == ONE) eng_stop = 1'b1;
                    else begin eng_rd = 1'b1; eng_nack = (len_q == TWO); end
                end
                S_WRITE:  eng_stop = (len_q == '0);
                default:  ;
            endcase
        end
        if (st_q == S_FETCH) begin
            tx_ready = 1'b1;
            if (tx_valid) begin
                eng_wr    = 1'b1;
                eng_wbyte = tx_data;
            end
        end
    end

    assign rx_data   = ev_rbyte;
    assign rcv_valid = (st_q == S_RECOV);
    assign rcv_op    = step_q;
    assign done      = (st_q == S_DONE);
    assign result    = res_q;
    assign busy      = (st_q != S_IDLE);
    assign spurious  = spur_q;

endmodule

// File: rtl/smbus_seq_chk.sv
module smbus_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       go,
    input logic       tx_ready,
    input logic       rx_valid,
    input logic       eng_start,
    input logic       eng_stop,
    input logic       eng_wr,
    input logic       eng_rd,
    input logic       ev_done,
    input logic       rcv_valid,
    input logic [2:0] rcv_op,
    input logic       done,
    input logic [1:0] result,
    input logic       busy,
    input logic       spurious
);
    // R12
    spur_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spurious |=> spurious);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !go) |-> !(eng_start || eng_wr || eng_rd || eng_stop));

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R11
    rcv_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_valid && rcv_op != 3'd0) |-> ($past(rcv_valid) && rcv_op == $past(rcv_op) + 3'd1));

    // R11
    rcv_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_valid && rcv_op == 3'd6) |=> (done && result == 2'd2));

    // R5
    inval_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 2'd3) |-> $past(go && !busy));

    // R6
    rx_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ev_done);

    // R7
    one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eng_rd, eng_stop, tx_ready && eng_rd}) && !(eng_wr && eng_rd));
endmodule

bind smbus_seq smbus_seq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .tx_ready  (tx_ready),
    .rx_valid  (rx_valid),
    .eng_start (eng_start),
    .eng_stop  (eng_stop),
    .eng_wr    (eng_wr),
    .eng_rd    (eng_rd),
    .ev_done   (ev_done),
    .rcv_valid (rcv_valid),
    .rcv_op    (rcv_op),
    .done      (done),
    .result    (result),
    .busy      (busy),
    .spurious  (spurious)
);

// File: tb/smbus_seq_tb_top.sv
module smbus_seq_tb_top;
    localparam int TMO = 40;
    localparam int LAT = 3;
    localparam int K_START = 1, K_WR = 2, K_RD = 3, K_STOP = 4, K_SW = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n, go, rd, tx_valid, tx_ready, rx_valid;
    logic [6:0] tgt_addr;
    logic [7:0] cmd, blk_len, tx_data, rx_data, eng_wbyte, ev_rbyte;
    logic [2:0] xtype, rcv_op;
    logic       eng_start, eng_stop, eng_wr, eng_rd, eng_nack;
    logic       ev_done, ev_nack, ev_berr, ev_master, rcv_valid, done, busy, spurious;
    logic [1:0] result;

    smbus_seq #(.LEN_W(8), .TMO_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .go(go), .tgt_addr(tgt_addr), .rd(rd), .cmd(cmd),
        .xtype(xtype), .blk_len(blk_len), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .eng_start(eng_start), .eng_stop(eng_stop), .eng_wr(eng_wr),
        .eng_wbyte(eng_wbyte), .eng_rd(eng_rd), .eng_nack(eng_nack),
        .ev_done(ev_done), .ev_rbyte(ev_rbyte), .ev_nack(ev_nack), .ev_berr(ev_berr),
        .ev_master(ev_master), .rcv_valid(rcv_valid), .rcv_op(rcv_op), .done(done),
        .result(result), .busy(busy), .spurious(spurious)
    );

    int n_chk = 0, n_fail = 0;
    int expq[$], txq[$], gen_rx[$], got_rx[$], got_rcv[$];
    int pend = -1, evn = 0, fmode = 0, fk = 0, cyc = 0, op_cyc = 0, rcv_cyc = 0, got_res = 0;
    bit pend_rd = 0, inj_spur = 0, go_drv = 0, got_done = 0, finished = 0;
    int rb_next = 8'h3C;
    string cur_tag = "R0";

    function automatic void chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endfunction

    // drive at negedge, observe 1 ns later
    task automatic tick();
        int code;
        @(negedge clk);
        go = go_drv; ev_done = 0; ev_nack = 0; ev_berr = 0; ev_master = 1; ev_rbyte = 8'h00;
        if (inj_spur) ev_done = 1;
        if (pend == 0) begin
            pend = -1;
            evn++;
            if (fk == evn && fmode == 1) ev_nack = 1;
            else if (fk == evn && fmode == 2) ev_berr = 1;
            else if (fk == evn && fmode == 3) begin ev_done = 1; ev_master = 0; end
            else if (fk == evn && fmode == 4) ;
            else begin
                ev_done = 1;
                if (pend_rd) begin
                    ev_rbyte = 8'(rb_next);
                    gen_rx.push_back(rb_next);
                    rb_next = (rb_next * 5 + 3) & 255;
                end
            end
        end else if (pend > 0) pend--;
        tx_valid = (txq.size() > 0);
        tx_data  = tx_valid ? 8'(txq[0]) : 8'h00;
        #1;
        code = -1;
        if (eng_start && eng_wr) code = (K_SW << 10) | eng_wbyte;
        else if (eng_start)      code = K_START << 10;
        else if (eng_wr)         code = (K_WR << 10) | eng_wbyte;
        else if (eng_rd)         code = (K_RD << 10) | (int'(eng_nack) << 8);
        else if (eng_stop)       code = K_STOP << 10;
        if (code >= 0) begin
            if (expq.size() == 0) chk(0, cur_tag, "unexpected engine op", code, -1);
            else begin
                int e;
                e = expq.pop_front();
                chk(code == e, cur_tag, "engine op", code, e);
            end
            if (!eng_stop) begin pend = LAT; pend_rd = eng_rd; op_cyc = cyc; end
        end
        if (rx_valid) got_rx.push_back(int'(rx_data));
        if (tx_valid && tx_ready) void'(txq.pop_front());
        if (rcv_valid) begin
            if (got_rcv.size() == 0) rcv_cyc = cyc;
            got_rcv.push_back(int'(rcv_op));
        end
        if (done) begin got_done = 1; got_res = int'(result); end
        cyc++;
    endtask

    task automatic run_txn(string tag, int xt, bit rdf, int addr, int cmdb, int blen,
                           int fm, int k, bit go_mid);
        int len, exp_res, ops[$];
        cur_tag = tag;
        expq.delete(); txq.delete(); gen_rx.delete(); got_rx.delete(); got_rcv.delete();
        evn = 0; fmode = fm; fk = k; pend = -1; got_done = 0;
        len = (xt == 0) ? 0 : (xt <= 2) ? 1 : (xt == 3) ? 2 : (xt == 4) ? blen : 0;
        exp_res = 0;
        if (rdf && len == 0) exp_res = 3;
        else begin
            ops.push_back(K_START << 10);
            if (xt >= 2) begin
                ops.push_back((K_WR << 10) | ((addr << 1) & 255));
                ops.push_back((K_WR << 10) | cmdb);
                if (rdf) ops.push_back((K_SW << 10) | (((addr << 1) | 1) & 255));
            end else ops.push_back((K_WR << 10) | (((addr << 1) | int'(rdf)) & 255));
            for (int i = 0; i < len; i++) begin
                if (rdf) ops.push_back((K_RD << 10) | ((i == len - 1) ? 256 : 0));
                else begin
                    int b;
                    b = (i * 37 + 11 + xt * 16) & 255;
                    txq.push_back(b);
                    ops.push_back((K_WR << 10) | b);
                end
            end
            if (fm != 0) begin
                while (ops.size() > k) void'(ops.pop_back());
                if (fm == 1) begin ops.push_back(K_STOP << 10); exp_res = 1; end
                else exp_res = 2;
            end else ops.push_back(K_STOP << 10);
        end
        expq = ops;
        xtype = 3'(xt); rd = rdf; tgt_addr = 7'(addr); cmd = 8'(cmdb); blk_len = 8'(blen);
        go_drv = 1; tick(); go_drv = 0;
        for (int n = 0; n < 3000 && !got_done; n++) begin
            go_drv = go_mid && (n == 6);
            tgt_addr = go_drv ? 7'h7F : 7'(addr);
            tick();
        end
        go_drv = 0;
        chk(got_done, tag, "watchdog: no done", 0, 1);
        chk(got_res == exp_res, tag, "result", got_res, exp_res);
        chk(expq.size() == 0, tag, "missing engine ops", expq.size(), 0);
        if (exp_res == 2) begin
            // R11 recovery step order
            chk(got_rcv.size() == 7, "R11", "recovery step count", got_rcv.size(), 7);
            for (int i = 0; i < got_rcv.size(); i++)
                chk(got_rcv[i] == i, "R11", "recovery step code", got_rcv[i], i);
        end else chk(got_rcv.size() == 0, tag, "recovery ran", got_rcv.size(), 0);
        if (fm == 4) chk(rcv_cyc - op_cyc == TMO + 1, "R10", "timeout latency",
                         rcv_cyc - op_cyc, TMO + 1);
        if (rdf && exp_res == 0) begin
            chk(got_rx.size() == len, "R6", "rx byte count", got_rx.size(), len);
            for (int i = 0; i < got_rx.size() && i < gen_rx.size(); i++)
                chk(got_rx[i] == gen_rx[i], "R6", "rx byte", got_rx[i], gen_rx[i]);
        end
        if (!rdf && exp_res == 0) chk(txq.size() == 0, "R7", "tx bytes left", txq.size(), 0);
        tick();
        // R13
        chk(!busy && !done, "R13", "busy/done after done pulse", {busy, done}, 0);
    endtask

    initial begin
        rst_n = 0; go = 0; rd = 0; tgt_addr = 0; cmd = 0; xtype = 0; blk_len = 0;
        tx_data = 0; tx_valid = 0; ev_done = 0; ev_rbyte = 0; ev_nack = 0; ev_berr = 0;
        ev_master = 1;
        repeat (3) tick();
        rst_n = 1;
        tick();
        chk(!busy && !done && !spurious && !rcv_valid, "R13", "reset state",
            {busy, done, spurious, rcv_valid}, 0);
        // R12 idle event
        cur_tag = "R12";
        inj_spur = 1; tick(); inj_spur = 0; tick();
        chk(spurious && !busy, "R12", "spurious set, still idle", {spurious, busy}, 2);
        tick();
        chk(spurious, "R12", "spurious sticky", spurious, 1);

        run_txn("R3",  0, 0, 7'h50, 8'h00, 0, 0, 0, 0);   // quick write
        run_txn("R3",  1, 0, 7'h21, 8'h00, 0, 0, 0, 0);   // byte write
        run_txn("R6",  1, 1, 7'h33, 8'h00, 0, 0, 0, 0);   // byte read, single nack
        run_txn("R1",  2, 0, 7'h48, 8'h9A, 0, 0, 0, 0);   // byte-data write
        run_txn("R2",  3, 1, 7'h2C, 8'h05, 0, 0, 0, 0);   // word read
        run_txn("R4",  4, 0, 7'h11, 8'h40, 5, 0, 0, 1);   // block write, go while busy (R13)
        run_txn("R4",  4, 1, 7'h6E, 8'h41, 4, 0, 0, 0);   // block read
        run_txn("R6",  4, 1, 7'h6E, 8'h42, 1, 0, 0, 0);   // block read of one
        run_txn("R5",  0, 1, 7'h22, 8'h00, 0, 0, 0, 0);   // quick read rejected
        run_txn("R5",  4, 1, 7'h22, 8'h10, 0, 0, 0, 0);   // empty block read rejected
        run_txn("R7",  4, 0, 7'h19, 8'h77, 0, 0, 0, 0);   // empty block write
        run_txn("R8",  2, 0, 7'h48, 8'h9A, 0, 1, 2, 0);   // nack on address
        run_txn("R8",  4, 0, 7'h19, 8'h20, 6, 1, 5, 0);   // nack mid data
        run_txn("R9",  3, 1, 7'h2C, 8'h05, 0, 2, 3, 0);   // bus error
        run_txn("R9",  1, 1, 7'h01, 8'h00, 0, 3, 1, 0);   // lost bus
        run_txn("R10", 2, 1, 7'h5A, 8'h0E, 0, 4, 2, 0);   // timeout

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R13 watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule